// File: doc/BRIEF.md
# Multi-mode addressable bit latch

This block keeps a small bank of storage bits, eight by default. One data input, one bit address and two active-low controls decide, on every rising clock edge, what happens to the bank. The first control is a write enable. The second is a conditional clear. Together they select one of four modes:

- write one addressed bit;
- keep everything;
- behave as a one-of-eight demultiplexer, with every other output low;
- clear the whole bank.

Every stored bit has its own output pin, so the whole bank can be read in parallel. Stepping the address while writing one bit per cycle turns the block into a serial-to-parallel converter. Holding the data input high in demultiplexer mode makes it an active-high one-hot address decoder.

The block is a clocked equivalent of a level-sensitive latch bank. Inputs are sampled on the rising clock edge, and the outputs show the result after that same edge. A separate asynchronous power-on reset clears the bank. That reset is released in step with the clock.

Top module: `addr_latch_bank`

## Requirements
- R1: While `rst_n` is low, all outputs are zero at once, without waiting for a clock edge. After `rst_n` is released, the bank stays clear until it is written.
- R2: Write mode is `clr_n`=1 and `wr_en_n`=0. At the edge, the bit selected by `sel` takes `din`, and every other bit keeps its value.
- R3: Hold mode is `clr_n`=1 and `wr_en_n`=1. No bit changes, whatever `din` and `sel` do.
- R4: Demultiplexer mode is `clr_n`=0 and `wr_en_n`=0. The selected output takes `din` and all other outputs go low. With `din`=1 the outputs form a one-hot code of `sel`.
- R5: Clear mode is `clr_n`=0 and `wr_en_n`=1. All outputs go low, whatever `din` and `sel` are.
- R6: `sel` is a plain binary number with bit 0 as its least significant bit. The value n selects output bit `q[n]`.
- R7: Demultiplexer mode writes the bank itself. A later hold therefore keeps showing the demultiplexed pattern.
- R8: When `wr_en_n` returns high, the bank keeps the data sampled on the last edge at which the write enable was low. Data present in the cycle the enable goes high is not stored.
- R9: Eight consecutive writes to addresses 0 through 7 assemble the serial bits into one parallel word, and that word is kept by a following hold.
- R10: Outputs change only at a rising clock edge, one edge after the inputs are sampled. A change on the inputs between edges does not reach `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| din | input | 1 | Serial data bit |
| sel | input | AW (3) | Bit address, binary, with bit 0 as the LSB |
| wr_en_n | input | 1 | Write enable, active low |
| clr_n | input | 1 | Conditional clear, active low; its effect depends on `wr_en_n` |
| q | output | 2**AW (8) | Stored bits, one output per bit |

## Verification
The bench loads several starting words into the bank. From each one it sweeps every address and data value through all four modes. A design that mixed up the two control inputs, or swapped demultiplexer and clear, would show its error against this sweep straight away. Separate checks cover the following mistakes and what each would look like:

- A reversed address order would light the mirrored bit.
- A demultiplexer that drove only the outputs, without writing the bank, would lose its pattern at the next hold.
- A write that also cleared its neighbours would corrupt a serial load.
- Logic that let input changes between edges reach `q` would show up when the inputs are changed between edges and `q` is read before the next edge.

// File: rtl/alb_pkg.sv
package alb_pkg;

  // Operating mode, formed from the two active-low controls.
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,  // clear low, enable low
    MODE_CLEAR = 2'b01,  // clear low, enable high
    MODE_WRITE = 2'b10,  // clear high, enable low
    MODE_HOLD  = 2'b11   // clear high, enable high
  } alb_mode_e;

  function automatic alb_mode_e alb_mode_of(input logic clr_n, input logic wr_en_n);
    return alb_mode_e'({clr_n, wr_en_n});
  endfunction

endpackage

// File: rtl/alb_reset_sync.sv
module alb_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/alb_mode_decode.sv
module alb_mode_decode
  import alb_pkg::*;
(
  input  logic      clr_n,
  input  logic      wr_en_n,
  output alb_mode_e mode,
  output logic      bank_ce
);
  always_comb begin
    mode    = alb_mode_of(clr_n, wr_en_n);
    bank_ce = (mode != MODE_HOLD);
  end
endmodule

// File: rtl/alb_sel_decode.sv
module alb_sel_decode #(
  parameter int AW = 3,
  localparam int NBITS = 1 << AW
) (
  input  logic [AW-1:0]    sel,
  output logic [NBITS-1:0] hit
);
  for (genvar i = 0; i < NBITS; i++) begin : g_hit
    assign hit[i] = (sel == AW'(i));
  end
endmodule

// File: rtl/alb_bank.sv
module alb_bank
  import alb_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  alb_mode_e        mode,
  input  logic             bank_ce,
  input  logic             din,
  input  logic [NBITS-1:0] hit,
  output logic [NBITS-1:0] store_q
);
  logic [NBITS-1:0] store_d;

  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    always_comb begin
      unique case (mode)
        MODE_WRITE: store_d[i] = hit[i] ? din : store_q[i];
        MODE_DEMUX: store_d[i] = hit[i] & din;
        MODE_CLEAR: store_d[i] = 1'b0;
        default:    store_d[i] = store_q[i];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       store_q <= '0;
    else if (bank_ce) store_q <= store_d;
  end
endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
  import alb_pkg::*;
#(
  parameter int AW = 3,
  localparam int NBITS = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [AW-1:0]    sel,
  input  logic             wr_en_n,
  input  logic             clr_n,
  output logic [NBITS-1:0] q
);
  logic             rst_sync_n;
  alb_mode_e        mode;
  logic             bank_ce;
  logic [NBITS-1:0] hit;

  alb_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  alb_mode_decode u_mode (
    .clr_n   (clr_n),
    .wr_en_n (wr_en_n),
    .mode    (mode),
    .bank_ce (bank_ce)
  );

  alb_sel_decode #(.AW(AW)) u_sel (
    .sel (sel),
    .hit (hit)
  );

  alb_bank #(.NBITS(NBITS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mode    (mode),
    .bank_ce (bank_ce),
    .din     (din),
    .hit     (hit),
    .store_q (q)
  );
endmodule

// File: rtl/alb_checker.sv
module alb_checker #(
  parameter int AW = 3,
  localparam int NBITS = 1 << AW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             din,
  input logic [AW-1:0]    sel,
  input logic             wr_en_n,
  input logic             clr_n,
  input logic [NBITS-1:0] q
);
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_ZERO: assert (q == '0); // R1
  end

  AST_WRITE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && clr_n && !wr_en_n) |=> (q[$past(sel)] == $past(din))); // R2

  AST_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && clr_n && !wr_en_n) |=> ($countones(q ^ $past(q)) <= 1)); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && clr_n && wr_en_n) |=> $stable(q)); // R3

  AST_DEMUX_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !clr_n && !wr_en_n) |=> (q == (NBITS'($past(din)) << $past(sel)))); // R4

  AST_DEMUX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !clr_n && !wr_en_n) |=> $onehot0(q)); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && wr_en_n) |=> (q == '0)); // R5
endmodule

bind addr_latch_bank alb_checker #(.AW(AW)) u_alb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .din        (din),
  .sel        (sel),
  .wr_en_n    (wr_en_n),
  .clr_n      (clr_n),
  .q          (q)
);

// File: tb/tb_addr_latch_bank.sv
`timescale 1ns/1ps
module tb_addr_latch_bank;
  localparam int AW = 3;
  localparam int NB = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, din, wr_en_n, clr_n;
  logic [AW-1:0] sel;
  logic [NB-1:0] q;
  logic [NB-1:0] exp_q;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_latch_bank #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .sel(sel),
    .wr_en_n(wr_en_n), .clr_n(clr_n), .q(q)
  );

  task automatic check(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negative edge: drive inputs, confirm q is still unchanged,
  // then take one rising edge, update the model and compare at the next negative edge.
  task automatic step(input logic c, input logic e, input logic [AW-1:0] a, input logic d,
                      input string req);
    clr_n = c; wr_en_n = e; sel = a; din = d;
    #1 check("R10", q, exp_q);
    @(posedge clk);
    case ({c, e})
      2'b10: exp_q[a] = d;
      2'b11: ;
      2'b00: exp_q = NB'(d) << a;
      default: exp_q = '0;
    endcase
    @(negedge clk);
    check(req, q, exp_q);
  endtask

  task automatic load_word(input logic [NB-1:0] w);
    for (int i = 0; i < NB; i++) step(1'b1, 1'b0, AW'(i), w[i], "R9");
  endtask

  task automatic power_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1", q, '0);
    exp_q = '0;
    @(negedge clk);
    rst_n = 1'b1;
    clr_n = 1'b1; wr_en_n = 1'b1; din = 1'b1; sel = '1;
    repeat (3) @(negedge clk);
    check("R1", q, '0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: timeout expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
    clr_n = 1'b1; wr_en_n = 1'b1; din = 1'b0; sel = '0;
    exp_q = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    #1 check("R1", q, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", q, '0);

    // R9: serial-to-parallel load, then hold with the inputs moving about
    load_word(8'hC6);
    check("R9", q, 8'hC6);
    for (int i = 0; i < NB; i++) step(1'b1, 1'b1, AW'(i), i[0], "R9");
    check("R9", q, 8'hC6);

    // Sweep all modes, addresses and data values from several start words.
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int a = 0; a < NB; a++) begin
          for (int d = 0; d < 2; d++) begin
            load_word(pats[p]);
            case (m)
              0: step(1'b1, 1'b0, AW'(a), d[0], "R2");
              1: step(1'b1, 1'b1, AW'(a), d[0], "R3");
              2: step(1'b0, 1'b0, AW'(a), d[0], "R4");
              default: step(1'b0, 1'b1, AW'(a), d[0], "R5");
            endcase
          end
        end
      end
    end

    // R6: bit order of the address
    step(1'b0, 1'b1, '0, 1'b0, "R5");
    step(1'b1, 1'b0, 3'b001, 1'b1, "R6");
    check("R6", q, 8'h02);
    step(1'b1, 1'b0, 3'b100, 1'b1, "R6");
    check("R6", q, 8'h12);

    // R4: one-hot decoding over every address
    for (int a = 0; a < NB; a++) begin
      step(1'b0, 1'b0, AW'(a), 1'b1, "R4");
      check("R4", q, NB'(1) << a);
    end

    // R7: demux contents stay visible through a hold
    step(1'b0, 1'b0, 3'd5, 1'b1, "R7");
    step(1'b1, 1'b1, 3'd0, 1'b1, "R7");
    check("R7", q, 8'h20);
    step(1'b1, 1'b1, 3'd7, 1'b0, "R7");
    check("R7", q, 8'h20);

    // R8: data in the cycle the enable rises is not stored
    step(1'b1, 1'b0, 3'd2, 1'b1, "R8");
    step(1'b1, 1'b1, 3'd2, 1'b0, "R8");
    check("R8", q, 8'h24);

    // R1: reset in the middle of operation
    load_word(8'h5A);
    power_reset();
    step(1'b1, 1'b1, 3'd3, 1'b1, "R1");
    check("R1", q, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule